// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and turns them into two processor request lines: a normal request chosen by priority arbitration, and a fast request for urgent sources. Each source carries an enable bit, a class bit, a 4-bit priority and a software force bit. All of these sit behind a single-cycle 32-bit register port with an 8-bit byte address. Per-source state is stored in two 32-bit words. The high word holds sources 63..32 and the low word holds sources 31..0.

A handler reads the normal vector register to get the number of the winning source, services that source, and reads the register again. It stops when bits 31:16 read 0xFFFF. One source can be enabled or disabled by writing its number, which avoids a read-modify-write of the enable words. A 5-bit mask level holds back normal requests of low priority. The vector register still names the winner while its request is held back. Register reads are combinational on the address. Writes take effect at the next rising clock edge.

Top module: `vect_irq_ctrl`

## Requirements
- R1: After reset, control (0x00) reads 0. Every enable, class, force and priority word reads 0. The normal vector (0x40) reads 0xFFFF0000 and both request outputs are low.
- R2: A source is pending when (raw input OR force bit) AND its enable bit are set. Normal pending words (high 0x58, low 0x5C) show pending sources whose class bit is 0. Fast pending words (high 0x60, low 0x64) show pending sources whose class bit is 1. In every high word, bit j is source 32+j.
- R3: Writing a value N below 64 to 0x08 sets enable bit N, and writing N to 0x0C clears it. Any written value of 64 or more leaves all enable bits unchanged.
- R4: The normal vector (0x40) holds the number of the normal pending source with the highest priority in bits 31:16 and that priority in bits 15:0. On equal priority, the higher source number wins. With no normal pending source it reads 0xFFFF0000.
- R5: irq_norm is high only when a normal source is pending and either the mask level is 0x1F or the winner's priority is strictly greater than the mask level.
- R6: The fast vector (0x44) holds the lowest-numbered fast pending source in bits 31:16 and 0 in bits 15:0, or 0xFFFF0000 when there is none. irq_fast is high exactly when a fast source is pending.
- R7: Priority word x (0..7) sits at byte address 0x20+4*(7-x). Its nibble k, at bits 4k+3..4k, is the priority of source 8x+k. Each word reads back what was written.
- R8: Enable (0x10/0x14), class (0x18/0x1C), force (0x50/0x54) and control (0x00) are read/write. The raw inputs read at 0x48 (high) and 0x4C (low).
- R9: A source whose enable bit is 0 reaches neither request, even when its force bit is set.
- R10: The mask level (0x04) is 5 bits wide and resets to 0x1F. Bits 31:5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| src_in | input | 64 | Level-sensitive interrupt inputs |
| irq_norm | output | 1 | Normal-class processor request |
| irq_fast | output | 1 | Fast-class processor request |

## Verification
The bench attacks equal-priority ties. A design that keeps the first match instead of the last would report the lower-numbered source. It probes the mask comparison exactly at equality, and at levels 16..30 that no 4-bit priority can exceed. An off-by-one or signed compare there would raise irq_norm wrongly. Enable-by-number writes of 64 and of all-ones check for index truncation, which would corrupt a real enable bit. The reversed priority word layout is checked by reads and by arbitration outcomes, which catches a design that places word x at the wrong offset. Forced sources that are disabled, class routing and a long random phase against a bench model cover gating, pending splits and the fast pick order.

// File: rtl/virq_pkg.sv
`timescale 1ns/1ps
package virq_pkg;
    // Register map assumes two 32-bit words per per-source field.
    localparam int NSRC        = 64;
    localparam int WORD_W      = 32;
    localparam int PRIO_W      = 4;
    localparam int MASK_W      = 5;
    localparam int ADDR_W      = 8;
    localparam int ID_W        = $clog2(NSRC);
    localparam int VEC_HALF    = 16;
    localparam int PER_PWORD   = WORD_W / PRIO_W;
    localparam int NPRIO_WORD  = NSRC / PER_PWORD;
    localparam int PIDX_W      = $clog2(NPRIO_WORD);

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ENUM  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DNUM  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_ENH   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ENL   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TYPH  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_TYPL  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_PTOP  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_PBOT  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_NVEC  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_FVEC  = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_SRCH  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_SRCL  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_FRCH  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_FRCL  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_NPNH  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_NPNL  = 8'h5C;
    localparam logic [ADDR_W-1:0] OFF_FPNH  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_FPNL  = 8'h64;

    localparam logic [VEC_HALF-1:0] NO_SRC = '1;

    typedef struct packed {
        logic [WORD_W-1:0]      ctrl;
        logic [MASK_W-1:0]      mask;
        logic [NSRC-1:0]        en;
        logic [NSRC-1:0]        typ;
        logic [NSRC-1:0]        frc;
        logic [NSRC*PRIO_W-1:0] prio;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ctrl: '0, mask: '1, en: '0, typ: '0, frc: '0, prio: '0};

    function automatic logic is_prio_addr(input logic [ADDR_W-1:0] a);
        return (a >= OFF_PTOP) && (a <= OFF_PBOT) && (a[1:0] == 2'b00);
    endfunction

    // Words are laid out in descending order from the lowest address.
    function automatic logic [PIDX_W-1:0] prio_word(input logic [ADDR_W-1:0] a);
        return PIDX_W'((NPRIO_WORD - 1) - int'((a - OFF_PTOP) >> 2));
    endfunction
endpackage

// File: rtl/virq_regfile.sv
`timescale 1ns/1ps
module virq_regfile
    import virq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic num_ok;

    assign num_ok = (wdata < WORD_W'(NSRC));

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                OFF_CTRL: cfg_d.ctrl = wdata;
                OFF_MASK: cfg_d.mask = wdata[MASK_W-1:0];
                OFF_ENUM: if (num_ok) cfg_d.en[wdata[ID_W-1:0]] = 1'b1;
                OFF_DNUM: if (num_ok) cfg_d.en[wdata[ID_W-1:0]] = 1'b0;
                OFF_ENH:  cfg_d.en[NSRC-1:WORD_W]  = wdata;
                OFF_ENL:  cfg_d.en[WORD_W-1:0]     = wdata;
                OFF_TYPH: cfg_d.typ[NSRC-1:WORD_W] = wdata;
                OFF_TYPL: cfg_d.typ[WORD_W-1:0]    = wdata;
                OFF_FRCH: cfg_d.frc[NSRC-1:WORD_W] = wdata;
                OFF_FRCL: cfg_d.frc[WORD_W-1:0]    = wdata;
                default: begin
                    if (is_prio_addr(addr))
                        cfg_d.prio[prio_word(addr)*WORD_W +: WORD_W] = wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    p_num_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_ENUM && wdata < WORD_W'(NSRC)) |=> cfg_q.en[$past(wdata[ID_W-1:0])]);
    p_num_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_DNUM && wdata < WORD_W'(NSRC)) |=> !cfg_q.en[$past(wdata[ID_W-1:0])]);
    p_big_num_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == OFF_ENUM || addr == OFF_DNUM) && wdata >= WORD_W'(NSRC)) |=> $stable(cfg_q.en));
endmodule

// File: rtl/virq_norm_arb.sv
`timescale 1ns/1ps
module virq_norm_arb
    import virq_pkg::*;
(
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC*PRIO_W-1:0] prio,
    output logic                   valid,
    output logic [ID_W-1:0]        id,
    output logic [PRIO_W-1:0]      lvl
);
    // Scan upward; >= lets a later (higher) source take an equal priority.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!valid || prio[i*PRIO_W +: PRIO_W] >= lvl)) begin
                valid = 1'b1;
                id    = ID_W'(i);
                lvl   = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        if (valid) begin
            p_win_requests_r4: assert (req[id]);
        end
    end
endmodule

// File: rtl/virq_fast_pick.sv
`timescale 1ns/1ps
module virq_fast_pick
    import virq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output logic            valid,
    output logic [ID_W-1:0] id
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/vect_irq_ctrl.sv
`timescale 1ns/1ps
module vect_irq_ctrl
    import virq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_in,
    output logic              irq_norm,
    output logic              irq_fast
);
    cfg_t              cfg;
    logic [NSRC-1:0]   pend, npend, fpend;
    logic              n_valid, f_valid;
    logic [ID_W-1:0]   n_id, f_id;
    logic [PRIO_W-1:0] n_lvl;
    logic [WORD_W-1:0] nvec, fvec;

    virq_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    assign pend  = (src_in | cfg.frc) & cfg.en;
    assign npend = pend & ~cfg.typ;
    assign fpend = pend & cfg.typ;

    virq_norm_arb u_arb (
        .req   (npend),
        .prio  (cfg.prio),
        .valid (n_valid),
        .id    (n_id),
        .lvl   (n_lvl)
    );

    virq_fast_pick u_fast (
        .req   (fpend),
        .valid (f_valid),
        .id    (f_id)
    );

    assign nvec = n_valid ? {{(VEC_HALF-ID_W){1'b0}}, n_id, {(VEC_HALF-PRIO_W){1'b0}}, n_lvl}
                          : {NO_SRC, {VEC_HALF{1'b0}}};
    assign fvec = f_valid ? {{(VEC_HALF-ID_W){1'b0}}, f_id, {VEC_HALF{1'b0}}}
                          : {NO_SRC, {VEC_HALF{1'b0}}};

    assign irq_norm = n_valid && ((&cfg.mask) || ({1'b0, n_lvl} > cfg.mask));
    assign irq_fast = f_valid;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: bus_rdata = cfg.ctrl;
            OFF_MASK: bus_rdata = {{(WORD_W-MASK_W){1'b0}}, cfg.mask};
            OFF_ENH:  bus_rdata = cfg.en[NSRC-1:WORD_W];
            OFF_ENL:  bus_rdata = cfg.en[WORD_W-1:0];
            OFF_TYPH: bus_rdata = cfg.typ[NSRC-1:WORD_W];
            OFF_TYPL: bus_rdata = cfg.typ[WORD_W-1:0];
            OFF_NVEC: bus_rdata = nvec;
            OFF_FVEC: bus_rdata = fvec;
            OFF_SRCH: bus_rdata = src_in[NSRC-1:WORD_W];
            OFF_SRCL: bus_rdata = src_in[WORD_W-1:0];
            OFF_FRCH: bus_rdata = cfg.frc[NSRC-1:WORD_W];
            OFF_FRCL: bus_rdata = cfg.frc[WORD_W-1:0];
            OFF_NPNH: bus_rdata = npend[NSRC-1:WORD_W];
            OFF_NPNL: bus_rdata = npend[WORD_W-1:0];
            OFF_FPNH: bus_rdata = fpend[NSRC-1:WORD_W];
            OFF_FPNL: bus_rdata = fpend[WORD_W-1:0];
            default: begin
                if (is_prio_addr(bus_addr))
                    bus_rdata = cfg.prio[prio_word(bus_addr)*WORD_W +: WORD_W];
            end
        endcase
    end

    p_winner_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        n_valid |-> (cfg.en[n_id] && !cfg.typ[n_id]));
    p_mask_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cfg.mask) && ({1'b0, n_lvl} <= cfg.mask)) |-> !irq_norm);
    p_fast_src_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (cfg.en[f_id] && cfg.typ[f_id]));
    p_norm_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> |(cfg.en & ~cfg.typ));
    p_fast_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> |(cfg.en & cfg.typ));
endmodule

// File: tb/sim_vect_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vect_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_norm, irq_fast;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_ctrl;
    logic [4:0]  m_mask;
    logic [63:0] m_en, m_typ, m_frc;
    logic [3:0]  m_prio [64];

    always #2.5 clk = ~clk;

    vect_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            8'h00: m_ctrl = d;
            8'h04: m_mask = d[4:0];
            8'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
            8'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
            8'h10: m_en[63:32] = d;
            8'h14: m_en[31:0] = d;
            8'h18: m_typ[63:32] = d;
            8'h1C: m_typ[31:0] = d;
            8'h50: m_frc[63:32] = d;
            8'h54: m_frc[31:0] = d;
            default: if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0)
                for (int k = 0; k < 8; k++)
                    m_prio[8 * (7 - ((a - 8'h20) >> 2)) + k] = d[4*k +: 4];
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_prio(input int s, input logic [3:0] p);
        logic [31:0] w;
        int x;
        x = s / 8;
        w = '0;
        for (int k = 0; k < 8; k++) w[4*k +: 4] = m_prio[8*x + k];
        w[4*(s % 8) +: 4] = p;
        wr(8'(8'h20 + 4 * (7 - x)), w);
    endtask

    function automatic logic [63:0] m_pend();
        return (src_in | m_frc) & m_en;
    endfunction

    function automatic logic [31:0] exp_nvec();
        int best; logic [3:0] bp;
        logic [63:0] p;
        best = -1; bp = 0; p = m_pend() & ~m_typ;
        for (int i = 0; i < 64; i++)
            if (p[i] && (best < 0 || m_prio[i] >= bp)) begin best = i; bp = m_prio[i]; end
        return (best < 0) ? 32'hFFFF0000 : {16'(best), 12'h0, bp};
    endfunction

    function automatic logic exp_irqn();
        logic [31:0] v;
        v = exp_nvec();
        return (v[31:16] != 16'hFFFF) && (m_mask == 5'h1F || {1'b0, v[3:0]} > m_mask);
    endfunction

    function automatic logic [31:0] exp_fvec();
        logic [63:0] p;
        p = m_pend() & m_typ;
        for (int i = 0; i < 64; i++) if (p[i]) return {16'(i), 16'h0};
        return 32'hFFFF0000;
    endfunction

    task automatic cmp_all(input string tag);
        logic [31:0] d;
        logic [63:0] p;
        p = m_pend();
        rd(8'h40, d); chk({tag, " nvec"}, d, exp_nvec());
        chk({tag, " irq_norm"}, 32'(irq_norm), 32'(exp_irqn()));
        rd(8'h44, d); chk({tag, " fvec"}, d, exp_fvec());
        chk({tag, " irq_fast"}, 32'(irq_fast), 32'(|(p & m_typ)));
        rd(8'h58, d); chk({tag, " npend hi"}, d, p[63:32] & ~m_typ[63:32]);
        rd(8'h5C, d); chk({tag, " npend lo"}, d, p[31:0] & ~m_typ[31:0]);
        rd(8'h60, d); chk({tag, " fpend hi"}, d, p[63:32] & m_typ[63:32]);
        rd(8'h64, d); chk({tag, " fpend lo"}, d, p[31:0] & m_typ[31:0]);
    endtask

    task automatic clr_all();
        src_in = '0;
        wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);
        wr(8'h50, 0); wr(8'h54, 0); wr(8'h04, 32'h1F);
        for (int x = 0; x < 8; x++) wr(8'(8'h20 + 4 * x), 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h04, d); chk("R10 mask reset", d, 32'h1F);
        rd(8'h10, d); chk("R1 en hi", d, 0);
        rd(8'h14, d); chk("R1 en lo", d, 0);
        rd(8'h1C, d); chk("R1 type lo", d, 0);
        rd(8'h54, d); chk("R1 force lo", d, 0);
        for (int x = 0; x < 8; x++) begin
            rd(8'(8'h20 + 4 * x), d); chk("R1 prio word", d, 0);
        end
        rd(8'h40, d); chk("R1 nvec", d, 32'hFFFF0000);
        chk("R1 irqs", {30'h0, irq_norm, irq_fast}, 0);
    endtask

    task automatic t_num_en();
        logic [31:0] d;
        wr(8'h08, 5); wr(8'h08, 40);
        rd(8'h14, d); chk("R3 en lo by num", d, 32'h20);
        rd(8'h10, d); chk("R3 en hi by num", d, 32'h100);
        wr(8'h08, 64); wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 100);
        rd(8'h14, d); chk("R3 big num ignored lo", d, 32'h20);
        rd(8'h10, d); chk("R3 big num ignored hi", d, 32'h100);
        wr(8'h0C, 5);
        rd(8'h14, d); chk("R3 disable by num", d, 0);
        wr(8'h04, 32'hFFFF_FFE3);
        rd(8'h04, d); chk("R10 mask width", d, 32'h03);
        wr(8'h00, 32'hA5A5_0F0F);
        rd(8'h00, d); chk("R8 ctrl rw", d, 32'hA5A5_0F0F);
        clr_all();
    endtask

    task automatic t_prio_map();
        logic [31:0] d;
        for (int x = 0; x < 8; x++) wr(8'(8'h20 + 4 * (7 - x)), 32'h1234_5670 + 32'(x));
        for (int x = 0; x < 8; x++) begin
            rd(8'(8'h20 + 4 * (7 - x)), d); chk("R7 prio readback", d, 32'h1234_5670 + 32'(x));
        end
        clr_all();
        wr(8'h3C, 32'h0000_2000);
        wr(8'h20, 32'h0009_0000);
        wr(8'h08, 3); wr(8'h08, 60);
        src_in = (64'h1 << 3) | (64'h1 << 60);
        rd(8'h40, d); chk("R7 word7 nibble4 is src60", d, {16'd60, 16'd9});
        wr(8'h20, 0);
        rd(8'h40, d); chk("R7 word0 nibble3 is src3", d, {16'd3, 16'd2});
        clr_all();
    endtask

    task automatic t_arb();
        logic [31:0] d;
        set_prio(10, 5); set_prio(20, 7); set_prio(30, 7);
        wr(8'h08, 10); wr(8'h08, 20); wr(8'h08, 30);
        src_in = (64'h1 << 10) | (64'h1 << 20) | (64'h1 << 30);
        rd(8'h40, d); chk("R4 tie to higher number", d, {16'd30, 16'd7});
        src_in[30] = 1'b0;
        rd(8'h40, d); chk("R4 next winner", d, {16'd20, 16'd7});
        src_in = 64'h1 << 10;
        rd(8'h40, d); chk("R4 lower prio alone", d, {16'd10, 16'd5});
        src_in = '0;
        rd(8'h40, d); chk("R4 empty sentinel", d, 32'hFFFF0000);
        clr_all();
    endtask

    task automatic t_mask();
        logic [31:0] d;
        set_prio(44, 7); wr(8'h08, 44);
        src_in = 64'h1 << 44;
        wr(8'h04, 7);
        #1 chk("R5 equal to mask holds", 32'(irq_norm), 0);
        rd(8'h40, d); chk("R5 vector visible while held", d, {16'd44, 16'd7});
        wr(8'h04, 6);
        #1 chk("R5 above mask raises", 32'(irq_norm), 1);
        wr(8'h04, 16);
        #1 chk("R5 level 16 blocks", 32'(irq_norm), 0);
        wr(8'h04, 30);
        #1 chk("R5 level 30 blocks", 32'(irq_norm), 0);
        wr(8'h04, 31);
        #1 chk("R5 level 31 disables mask", 32'(irq_norm), 1);
        set_prio(44, 0); wr(8'h04, 0);
        #1 chk("R5 prio 0 vs mask 0", 32'(irq_norm), 0);
        clr_all();
    endtask

    task automatic t_fast();
        logic [31:0] d;
        wr(8'h1C, 32'h1000); wr(8'h18, 32'h4_0000);
        wr(8'h08, 12); wr(8'h08, 50); wr(8'h08, 7);
        src_in = (64'h1 << 12) | (64'h1 << 50);
        rd(8'h44, d); chk("R6 lowest fast", d, {16'd12, 16'd0});
        chk("R6 irq_fast", 32'(irq_fast), 1);
        rd(8'h40, d); chk("R2 fast not in normal vec", d, 32'hFFFF0000);
        rd(8'h60, d); chk("R2 fast pend hi", d, 32'h4_0000);
        rd(8'h5C, d); chk("R2 normal pend lo empty", d, 0);
        src_in[12] = 1'b0; src_in[7] = 1'b1;
        rd(8'h44, d); chk("R6 remaining fast", d, {16'd50, 16'd0});
        rd(8'h5C, d); chk("R2 normal pend lo", d, 32'h80);
        src_in[50] = 1'b0;
        rd(8'h44, d); chk("R6 fast sentinel", d, 32'hFFFF0000);
        chk("R6 irq_fast low", 32'(irq_fast), 0);
        clr_all();
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(8'h50, 32'h2);
        rd(8'h50, d); chk("R8 force rw", d, 32'h2);
        chk("R9 forced disabled no req", {30'h0, irq_norm, irq_fast}, 0);
        rd(8'h58, d); chk("R9 forced disabled not pending", d, 0);
        wr(8'h10, 32'h2);
        rd(8'h58, d); chk("R2 forced enabled pending", d, 32'h2);
        chk("R2 forced raises", 32'(irq_norm), 1);
        wr(8'h18, 32'h2);
        chk("R9 forced fast enabled", {30'h0, irq_norm, irq_fast}, 1);
        wr(8'h10, 0);
        chk("R9 disable blocks fast", {30'h0, irq_norm, irq_fast}, 0);
        src_in = 64'hDEAD_BEEF_0BAD_F00D;
        rd(8'h48, d); chk("R8 raw hi", d, 32'hDEAD_BEEF);
        rd(8'h4C, d); chk("R8 raw lo", d, 32'h0BAD_F00D);
        chk("R9 raw but none enabled", {30'h0, irq_norm, irq_fast}, 0);
        clr_all();
    endtask

    task automatic t_random();
        for (int it = 0; it < 300; it++) begin
            case ($urandom_range(0, 5))
                0: wr(8'($urandom_range(0, 1) ? 8'h10 : 8'h14), $urandom);
                1: wr(8'($urandom_range(0, 1) ? 8'h18 : 8'h1C), $urandom & $urandom);
                2: wr(8'(8'h20 + 4 * $urandom_range(0, 7)), $urandom);
                3: wr(8'($urandom_range(0, 1) ? 8'h50 : 8'h54), $urandom & $urandom & $urandom);
                4: wr(8'h04, $urandom_range(0, 31));
                default: wr(8'($urandom_range(0, 1) ? 8'h08 : 8'h0C), $urandom_range(0, 70));
            endcase
            src_in = {$urandom, $urandom} & {$urandom, $urandom};
            cmp_all("R2/R4/R5/R6 random");
        end
        clr_all();
    endtask

    initial begin
        m_ctrl = '0; m_mask = 5'h1F; m_en = '0; m_typ = '0; m_frc = '0;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_num_en();
        t_prio_map();
        t_arb();
        t_mask();
        t_fast();
        t_force();
        t_random();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule